// File: doc/BRIEF.md
# Two-Channel Sequential Break Matcher

This block watches a processor's bus cycles, one candidate per clock, and raises a debug break request when a programmed condition is hit. Two comparator channels hold an address, an address mask and a control field. The control field selects the access kind to watch (instruction fetch, operand read or operand write) and, for fetches, whether the break is taken before or after the instruction executes. In independent mode either channel can trigger. In sequential mode a hit on channel 0 arms the unit, and only a later hit on channel 1 triggers.

The break is arbitrated against a companion "other exception pending" input. A before-execution break outranks any exception. Any other break gives way to the exception. A pair of sticky per-channel hit flags records every condition match.

Settings are written through a small indexed register port. Software can let a write take effect on the next cycle. It can also request staged updates, in which written values stay invisible to the comparators until a confirm sequence has run.

Top module: `ubk_break_unit`

## Requirements
- R1: After a synchronous reset, brk_req, brk_pre, exc_take and cond_flag are 0, every setting register reads back 0 and no staged update is pending.
- R2: A channel hits when all of the following are true: its control bit 0 (enable) is 1; its control bits 2:1 (kind: 01 fetch, 10 operand read, 11 operand write, 00 never) equal bus_kind; bus_valid is 1; and bus_addr equals the channel address on every bit where the mask register holds 0. Mask bits of 1 are not compared.
- R3: brk_req is registered: it is high for exactly the one cycle that follows a triggering bus cycle.
- R4: Control bit 3 selects the break timing only for fetch conditions, where 0 means before execution (brk_pre=1) and 1 means after execution. For read or write conditions the bit is ignored and the break is always after execution (brk_pre=0).
- R5: When sequential mode (register 6, bit 0) is 0, a hit on either channel triggers a break by itself.
- R6: When sequential mode is 1, a channel 0 hit arms the unit and only a channel 1 hit in a later cycle triggers a break. A channel 1 hit while the unit is not armed never triggers, and neither does a hit on both channels in the same unarmed cycle. The armed state clears when the break triggers or when sequential mode is 0.
- R7: exc_pending is sampled with the bus cycle. A before-execution break wins over it (brk_req=1, exc_take=0). An after-execution break is suppressed (brk_req=0, exc_take=1). With no break, exc_take follows exc_pending one cycle later.
- R8: cond_flag[n] becomes 1 after any hit of channel n in either mode and stays 1. Writing register 7 clears each flag whose wdata bit is 1, and a hit in the same cycle takes priority over the clear. Reading register 7 returns the flags in bits 1:0.
- R9: With imm_commit=0, writes to registers 0 to 6 are staged. They reach the comparators only after a write, then a read of that same register, then a write of the read-back value to it. That final write publishes every staged register at once. A write that breaks the sequence restarts it.
- R10: With imm_commit=1, a write to registers 0 to 6 is used by the comparators from the next cycle on.
- R11: Reads of registers 0 to 6 return the last written value, truncated to the field width: address and mask are 32 bits, control is 4 bits and mode is 1 bit. The register order is channel 0 address, mask and control, then channel 1 address, mask and control, then mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imm_commit | input | 1 | 1: writes take effect next cycle; 0: staged confirm sequence |
| cfg_we | input | 1 | Register write strobe |
| cfg_re | input | 1 | Register read strobe (advances the confirm sequence) |
| cfg_idx | input | 3 | Register index |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_idx (combinational) |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | 32 | Bus cycle address |
| bus_kind | input | 2 | Access kind: 01 fetch, 10 read, 11 write |
| exc_pending | input | 1 | Another exception on the same instruction |
| brk_req | output | 1 | Break request |
| brk_pre | output | 1 | Break is taken before execution |
| exc_take | output | 1 | The other exception is taken |
| cond_flag | output | 2 | Sticky per-channel hit flags |

## Verification
Two kinds of collision can happen in one cycle. In the first, both channels hit the same bus cycle. The bench provokes this by giving both channels the same fetch address and driving that address with sequential mode on, and it expects no break. In the second, a break and a pending exception arrive together. The bench drives exc_pending alongside a before-execution fetch hit and alongside an after-execution operand hit, and it expects the first to win over the exception and the second to lose to it. A behavioural model in the bench judges every cycle, and directed checks cover the reversed-order and armed-clear cases.

// File: rtl/ubk_pkg.sv
package ubk_pkg;

    localparam int ADDR_W      = 32;
    localparam int CFG_W       = 32;
    localparam int NUM_CH      = 2;
    localparam int REGS_PER_CH = 3;
    localparam int MODE_IDX    = REGS_PER_CH * NUM_CH;
    localparam int FLAG_IDX    = MODE_IDX + 1;
    localparam int NUM_CFG     = MODE_IDX + 1;
    localparam int REG_IDX_W   = $clog2(FLAG_IDX + 1);

    typedef enum logic [1:0] {
        ACC_NONE  = 2'b00,
        ACC_FETCH = 2'b01,
        ACC_READ  = 2'b10,
        ACC_WRITE = 2'b11
    } acc_e;

    // bit 3 post, bits 2:1 kind, bit 0 enable
    typedef struct packed {
        logic post;
        acc_e kind;
        logic en;
    } chan_ctl_t;

    localparam int CTL_W = $bits(chan_ctl_t);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] mask;
        chan_ctl_t         ctl;
    } chan_cfg_t;

    typedef struct packed {
        chan_cfg_t [NUM_CH-1:0] ch;
        logic                   seq_en;
    } unit_cfg_t;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_WROTE = 2'd1,
        TRK_READ  = 2'd2
    } trk_e;

    function automatic logic is_pre(chan_ctl_t c);
        return (c.kind == ACC_FETCH) && !c.post;
    endfunction

    function automatic logic [CFG_W-1:0] cfg_get(unit_cfg_t c, logic [REG_IDX_W-1:0] idx);
        logic [CFG_W-1:0] v;
        v = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (int'(idx) == REGS_PER_CH*k)     v[ADDR_W-1:0] = c.ch[k].addr;
            if (int'(idx) == REGS_PER_CH*k + 1) v[ADDR_W-1:0] = c.ch[k].mask;
            if (int'(idx) == REGS_PER_CH*k + 2) v[CTL_W-1:0]  = c.ch[k].ctl;
        end
        if (int'(idx) == MODE_IDX) v[0] = c.seq_en;
        return v;
    endfunction

    function automatic unit_cfg_t cfg_put(unit_cfg_t c, logic [REG_IDX_W-1:0] idx,
                                          logic [CFG_W-1:0] d);
        unit_cfg_t n;
        n = c;
        for (int k = 0; k < NUM_CH; k++) begin
            if (int'(idx) == REGS_PER_CH*k)     n.ch[k].addr = d[ADDR_W-1:0];
            if (int'(idx) == REGS_PER_CH*k + 1) n.ch[k].mask = d[ADDR_W-1:0];
            if (int'(idx) == REGS_PER_CH*k + 2) n.ch[k].ctl  = chan_ctl_t'(d[CTL_W-1:0]);
        end
        if (int'(idx) == MODE_IDX) n.seq_en = d[0];
        return n;
    endfunction

endpackage

// File: rtl/ubk_cfg_regs.sv
module ubk_cfg_regs
    import ubk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 imm_commit,
    input  logic                 we,
    input  logic                 re,
    input  logic [REG_IDX_W-1:0] idx,
    input  logic [CFG_W-1:0]     wdata,
    output logic [CFG_W-1:0]     rdata,
    output unit_cfg_t            act_cfg
);

    unit_cfg_t            shadow_q, active_q;
    trk_e                 trk_q;
    logic [REG_IDX_W-1:0] pidx_q;
    logic                 in_range, confirm;

    assign in_range = int'(idx) < NUM_CFG;
    assign confirm  = (trk_q == TRK_READ) && (idx == pidx_q) &&
                      (wdata == cfg_get(shadow_q, idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= '0;
            active_q <= '0;
            trk_q    <= TRK_IDLE;
            pidx_q   <= '0;
        end else if (we && in_range) begin
            shadow_q <= cfg_put(shadow_q, idx, wdata);
            if (imm_commit) begin
                active_q <= cfg_put(active_q, idx, wdata);
                trk_q    <= TRK_IDLE;
            end else if (confirm) begin
                active_q <= cfg_put(shadow_q, idx, wdata);
                trk_q    <= TRK_IDLE;
            end else begin
                trk_q  <= TRK_WROTE;
                pidx_q <= idx;
            end
        end else if (re && (trk_q == TRK_WROTE) && (idx == pidx_q)) begin
            trk_q <= TRK_READ;
        end
    end

    assign rdata   = cfg_get(shadow_q, idx);
    assign act_cfg = active_q;

endmodule

// File: rtl/ubk_chan.sv
module ubk_chan
    import ubk_pkg::*;
(
    input  chan_cfg_t         cfg,
    input  logic              bus_valid,
    input  logic [ADDR_W-1:0] bus_addr,
    input  acc_e              bus_kind,
    output logic              hit,
    output logic              pre
);

    logic addr_eq;

    assign addr_eq = ((bus_addr ^ cfg.addr) & ~cfg.mask) == '0;
    assign hit     = bus_valid && cfg.ctl.en && (cfg.ctl.kind != ACC_NONE) &&
                     (cfg.ctl.kind == bus_kind) && addr_eq;
    assign pre     = is_pre(cfg.ctl);

endmodule

// File: rtl/ubk_seq_arb.sv
module ubk_seq_arb
    import ubk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              seq_en,
    input  logic [NUM_CH-1:0] hit,
    input  logic [NUM_CH-1:0] pre,
    input  logic              exc_pending,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic              brk_req,
    output logic              brk_pre,
    output logic              exc_take,
    output logic [NUM_CH-1:0] cond_flag,
    output logic              armed
);

    logic              seq_fire, any_fire, any_pre, take;
    logic [NUM_CH-1:0] fire_vec;

    assign seq_fire = seq_en && armed && hit[NUM_CH-1];
    assign fire_vec = seq_en ? {seq_fire, {(NUM_CH-1){1'b0}}} : hit;
    assign any_fire = |fire_vec;
    assign any_pre  = |(fire_vec & pre);
    assign take     = any_fire && (any_pre || !exc_pending);

    always_ff @(posedge clk) begin
        if (rst) begin
            brk_req   <= 1'b0;
            brk_pre   <= 1'b0;
            exc_take  <= 1'b0;
            cond_flag <= '0;
            armed     <= 1'b0;
        end else begin
            brk_req  <= take;
            brk_pre  <= take && any_pre;
            exc_take <= exc_pending && !(any_fire && any_pre);
            if (!seq_en || seq_fire)
                armed <= 1'b0;
            else if (hit[0])
                armed <= 1'b1;
            cond_flag <= (cond_flag & ~(clr_we ? clr_mask : '0)) | hit;
        end
    end

endmodule

// File: rtl/ubk_break_unit.sv
module ubk_break_unit
    import ubk_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 imm_commit,
    input  logic                 cfg_we,
    input  logic                 cfg_re,
    input  logic [REG_IDX_W-1:0] cfg_idx,
    input  logic [CFG_W-1:0]     cfg_wdata,
    output logic [CFG_W-1:0]     cfg_rdata,
    input  logic                 bus_valid,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [1:0]           bus_kind,
    input  logic                 exc_pending,
    output logic                 brk_req,
    output logic                 brk_pre,
    output logic                 exc_take,
    output logic [NUM_CH-1:0]    cond_flag
);

    unit_cfg_t         act_cfg;
    logic [CFG_W-1:0]  reg_rdata;
    logic [NUM_CH-1:0] hit_w, pre_w;
    logic              armed_w, seq_en_w, flag_sel;

    ubk_cfg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .imm_commit (imm_commit),
        .we         (cfg_we),
        .re         (cfg_re),
        .idx        (cfg_idx),
        .wdata      (cfg_wdata),
        .rdata      (reg_rdata),
        .act_cfg    (act_cfg)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ubk_chan u_ch (
            .cfg       (act_cfg.ch[c]),
            .bus_valid (bus_valid),
            .bus_addr  (bus_addr),
            .bus_kind  (acc_e'(bus_kind)),
            .hit       (hit_w[c]),
            .pre       (pre_w[c])
        );
    end

    assign seq_en_w = act_cfg.seq_en;
    assign flag_sel = int'(cfg_idx) == FLAG_IDX;

    ubk_seq_arb u_arb (
        .clk         (clk),
        .rst         (rst),
        .seq_en      (seq_en_w),
        .hit         (hit_w),
        .pre         (pre_w),
        .exc_pending (exc_pending),
        .clr_we      (cfg_we && flag_sel),
        .clr_mask    (cfg_wdata[NUM_CH-1:0]),
        .brk_req     (brk_req),
        .brk_pre     (brk_pre),
        .exc_take    (exc_take),
        .cond_flag   (cond_flag),
        .armed       (armed_w)
    );

    assign cfg_rdata = flag_sel ? {{(CFG_W-NUM_CH){1'b0}}, cond_flag} : reg_rdata;

endmodule

// File: rtl/ubk_break_chk.sv
module ubk_break_chk
    import ubk_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_we,
    input logic              exc_pending,
    input logic              seq_en,
    input logic              armed,
    input logic [NUM_CH-1:0] hit,
    input logic              brk_req,
    input logic              brk_pre,
    input logic              exc_take,
    input logic [NUM_CH-1:0] cond_flag,
    input unit_cfg_t         act_cfg
);

    // R7
    brk_exc_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(brk_req && exc_take));

    // R4
    pre_implies_req_chk: assert property (@(posedge clk) disable iff (rst)
        brk_pre |-> brk_req);

    // R7
    exc_only_pre_chk: assert property (@(posedge clk) disable iff (rst)
        exc_pending |=> (!brk_req || brk_pre));

    // R6
    unarmed_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (seq_en && !armed) |=> !brk_req);

    // R5
    indep_trigger_chk: assert property (@(posedge clk) disable iff (rst)
        (!seq_en && (|hit)) |=> (brk_req || exc_take));

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (|hit) |=> ((cond_flag & $past(hit)) == $past(hit)));

    // R9
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(act_cfg));

endmodule

bind ubk_break_unit ubk_break_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .exc_pending (exc_pending),
    .seq_en      (seq_en_w),
    .armed       (armed_w),
    .hit         (hit_w),
    .brk_req     (brk_req),
    .brk_pre     (brk_pre),
    .exc_take    (exc_take),
    .cond_flag   (cond_flag),
    .act_cfg     (act_cfg)
);

// File: tb/sim_ubk_break_unit.sv
module sim_ubk_break_unit;

    localparam int CLK_PERIOD = 10;
    localparam logic [1:0] K_FETCH = 2'b01;
    localparam logic [1:0] K_READ  = 2'b10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        imm_commit = 1'b1;
    logic        cfg_we = 1'b0;
    logic        cfg_re = 1'b0;
    logic [2:0]  cfg_idx = 3'd0;
    logic [31:0] cfg_wdata = 32'd0;
    logic [31:0] cfg_rdata;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = 32'd0;
    logic [1:0]  bus_kind = 2'd0;
    logic        exc_pending = 1'b0;
    logic        brk_req, brk_pre, exc_take;
    logic [1:0]  cond_flag;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ubk_break_unit u0 (
        .clk(clk), .rst(rst), .imm_commit(imm_commit),
        .cfg_we(cfg_we), .cfg_re(cfg_re), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_kind(bus_kind),
        .exc_pending(exc_pending), .brk_req(brk_req), .brk_pre(brk_pre),
        .exc_take(exc_take), .cond_flag(cond_flag)
    );

    // behavioural reference model
    logic [31:0] m_sh [7];
    logic [31:0] m_act[7];
    int          m_stage, m_pidx;
    logic        m_armed, m_brk, m_pre, m_exc;
    logic [1:0]  m_flag, mh, mp, mf;

    function automatic logic [31:0] trunc(int i, logic [31:0] d);
        if (i == 6) return d & 32'h1;
        if (i % 3 == 2) return d & 32'hF;
        return d;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < 7; r++) begin m_sh[r] = 0; m_act[r] = 0; end
            m_stage = 0; m_pidx = 0; m_armed = 0;
            m_brk = 0; m_pre = 0; m_exc = 0; m_flag = 0;
        end else begin
            for (int c = 0; c < 2; c++) begin
                mh[c] = bus_valid && m_act[3*c+2][0] && (m_act[3*c+2][2:1] != 2'b00) &&
                        (m_act[3*c+2][2:1] == bus_kind) &&
                        (((bus_addr ^ m_act[3*c]) & ~m_act[3*c+1]) == 0);
                mp[c] = (m_act[3*c+2][2:1] == 2'b01) && !m_act[3*c+2][3];
            end
            if (m_act[6][0]) mf = {m_armed && mh[1], 1'b0};
            else mf = mh;
            m_brk = (mf != 0) && (((mf & mp) != 0) || !exc_pending);
            m_pre = m_brk && ((mf & mp) != 0);
            m_exc = exc_pending && !((mf & mp) != 0);
            if (!m_act[6][0] || (m_armed && mh[1])) m_armed = 0;
            else if (mh[0]) m_armed = 1;
            if (cfg_we && cfg_idx == 3'd7) m_flag = m_flag & ~cfg_wdata[1:0];
            m_flag = m_flag | mh;
            if (cfg_we && cfg_idx < 3'd7) begin
                if (imm_commit) begin
                    m_sh[cfg_idx] = trunc(int'(cfg_idx), cfg_wdata);
                    m_act[cfg_idx] = trunc(int'(cfg_idx), cfg_wdata);
                    m_stage = 0;
                end else if (m_stage == 2 && int'(cfg_idx) == m_pidx &&
                             cfg_wdata == m_sh[cfg_idx]) begin
                    for (int r = 0; r < 7; r++) m_act[r] = m_sh[r];
                    m_stage = 0;
                end else begin
                    m_sh[cfg_idx] = trunc(int'(cfg_idx), cfg_wdata);
                    m_stage = 1; m_pidx = int'(cfg_idx);
                end
            end else if (cfg_re && m_stage == 1 && int'(cfg_idx) == m_pidx) begin
                m_stage = 2;
            end
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check("R5 model brk_req", {31'd0, brk_req}, {31'd0, m_brk});
            check("R4 model brk_pre", {31'd0, brk_pre}, {31'd0, m_pre});
            check("R7 model exc_take", {31'd0, exc_take}, {31'd0, m_exc});
            check("R8 model cond_flag", {30'd0, cond_flag}, {30'd0, m_flag});
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] i, input logic [31:0] d);
        cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] i, output logic [31:0] d);
        cfg_re = 1'b1; cfg_idx = i;
        #1 d = cfg_rdata;
        tick();
        cfg_re = 1'b0;
    endtask

    task automatic bus(input logic [31:0] a, input logic [1:0] k, input logic e);
        bus_valid = 1'b1; bus_addr = a; bus_kind = k; exc_pending = e;
        tick();
        bus_valid = 1'b0; exc_pending = 1'b0;
    endtask

    task automatic expect3(input string tag, input logic b, input logic p, input logic x);
        check(tag, {29'd0, brk_req, brk_pre, exc_take}, {29'd0, b, p, x});
    endtask

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        expect3("R1 reset outputs", 0, 0, 0);
        check("R1 reset flags", {30'd0, cond_flag}, 32'd0);
        rd(3'd0, v);  check("R1 reset readback", v, 32'd0);

        // immediate programming
        wr(3'd0, 32'h1000); wr(3'd2, 32'h3);
        wr(3'd3, 32'h2000); wr(3'd5, 32'hFFFF_FFF5);
        rd(3'd5, v);  check("R11 ctl truncated", v, 32'h5);
        rd(3'd0, v);  check("R11 addr readback", v, 32'h1000);

        bus(32'h1000, K_FETCH, 0); expect3("R10 R3 R4 fetch pre break", 1, 1, 0);
        tick();                    expect3("R3 single cycle", 0, 0, 0);
        bus(32'h2000, K_READ, 0);  expect3("R4 operand ignores pre bit", 1, 0, 0);
        bus(32'h2000, K_FETCH, 0); expect3("R2 kind mismatch", 0, 0, 0);
        bus(32'h1004, K_FETCH, 0); expect3("R2 address mismatch", 0, 0, 0);
        wr(3'd1, 32'hF);
        bus(32'h100C, K_FETCH, 0); expect3("R2 masked bits ignored", 1, 1, 0);
        bus(32'h1010, K_FETCH, 0); expect3("R2 unmasked bit compared", 0, 0, 0);

        check("R8 flags set", {30'd0, cond_flag}, 32'h3);
        wr(3'd7, 32'h1);
        check("R8 flag clear", {30'd0, cond_flag}, 32'h2);
        rd(3'd7, v);  check("R8 flag readback", v, 32'h2);

        bus(32'h1000, K_FETCH, 1); expect3("R7 pre break beats exception", 1, 1, 0);
        bus(32'h2000, K_READ, 1);  expect3("R7 post break yields", 0, 0, 1);
        bus(32'h5000, K_READ, 1);  expect3("R7 exception alone", 0, 0, 1);
        wr(3'd2, 32'hB);
        bus(32'h1000, K_FETCH, 0); expect3("R4 fetch post break", 1, 0, 0);
        wr(3'd2, 32'h3);

        // sequential mode
        wr(3'd6, 32'h1);
        bus(32'h2000, K_READ, 0);  expect3("R6 reversed ch1 first", 0, 0, 0);
        bus(32'h1000, K_FETCH, 0); expect3("R6 ch0 only arms", 0, 0, 0);
        bus(32'h2000, K_READ, 0);  expect3("R6 ordered fires", 1, 0, 0);
        bus(32'h2000, K_READ, 0);  expect3("R6 armed cleared by fire", 0, 0, 0);
        bus(32'h1000, K_FETCH, 0); tick();
        bus(32'h2000, K_READ, 0);  expect3("R6 ordered with gap", 1, 0, 0);
        bus(32'h1000, K_FETCH, 0);
        wr(3'd6, 32'h0); wr(3'd6, 32'h1);
        bus(32'h2000, K_READ, 0);  expect3("R6 mode off clears arm", 0, 0, 0);
        wr(3'd3, 32'h1000); wr(3'd5, 32'h3);
        bus(32'h1000, K_FETCH, 0); expect3("R6 simultaneous no break", 0, 0, 0);
        wr(3'd6, 32'h0);

        // staged updates
        imm_commit = 1'b0;
        wr(3'd0, 32'h3000);
        rd(3'd0, v);  check("R11 staged readback", v, 32'h3000);
        wr(3'd0, 32'h3004);
        bus(32'h3004, K_FETCH, 0); expect3("R9 broken sequence not applied", 0, 0, 0);
        rd(3'd0, v);
        bus(32'h3004, K_FETCH, 0); expect3("R9 after read not applied", 0, 0, 0);
        wr(3'd0, v);
        bus(32'h3004, K_FETCH, 0); expect3("R9 confirm applied", 1, 1, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        done = 1'b1;
        checks++; fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule